// File: doc/BRIEF.md
# Side-Effecting Peripheral Register Bank

This block is the register front end of a byte-oriented serial peripheral. It answers a single-cycle bus: each cycle carries an address, a write strobe with a write byte, and a read strobe. Read data comes back combinationally in the same cycle. Two kinds of register sit side by side in the bank. Plain storage registers (a control byte and a parallel output byte) can be rewritten with the same value any number of times, and nothing changes. Access registers (the data port and the two interrupt status registers) change state on every access, so a repeated identical access gives a different result.

One address works as the data port in both directions. A write offers the byte to the transmit stream in the same cycle. A read takes the byte at the head of the receive stream. Both streams use a valid/ready handshake. Errors are kept in sticky flags: a write that the transmitter cannot accept is lost, and a read that finds no received byte returns zero. The parallel output byte drives pins directly. An interrupt line is raised whenever any status bit is set.

Top module: `mmio_sidefx_regs`

## Requirements
- R1: A write to address 0 while `tx_ready` is high raises `tx_valid` for that cycle only, with `tx_data` equal to the written byte. Each such write transfers exactly one byte, so two writes of the same value produce two transfers.
- R2: A write to address 0 while `tx_ready` is low raises no `tx_valid`, and the byte is lost. It sets bit 1 (overrun) of the clear-on-read status register at address 2.
- R3: A read of address 0 while `rx_valid` is high returns `rx_data` on `bus_rdata` in the same cycle and raises `rx_ready` for that cycle, which pops one byte.
- R4: A read of address 0 while `rx_valid` is low returns zero and leaves `rx_ready` low. It sets bit 0 (underrun) of the register at address 2.
- R5: The control register at address 1 stores each written byte and shows it on `ctrl_o` and on reads from the next cycle onward. Writing the value it already holds changes no output and has no side effect.
- R6: The output register at address 4 drives `pio_o` from its stored bits. Writing the same bits again leaves the pins unchanged.
- R7: A read of address 2 returns the overrun and underrun flags in bits 1:0 and clears both at the next edge. The next read returns zero unless a new event has occurred.
- R8: The event register at address 3 holds bit 0 (transmit accepted) and bit 1 (receive byte arrived). Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: Bit 0 of address 3 is set by each accepted transmit byte. Bit 1 is set in the cycle after `rx_valid` rises. When a set event and a write-1 clear of the same bit fall in the same cycle, the bit ends up set.
- R10: Addresses 5 to 7 read as zero, and writes to them change no register or output.
- R11: After reset every register and output is zero. `irq` is high exactly when any bit of address 2 or address 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Read data, valid in the strobe cycle, zero otherwise |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmitter can accept |
| tx_data | output | DW | Transmit byte |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Pop of the received byte |
| rx_data | input | DW | Received byte |
| ctrl_o | output | DW | Control register contents |
| pio_o | output | DW | Parallel output pins |
| irq | output | 1 | Any status bit set |

## Verification
The hardest case to reach from the ports is a hardware set landing in the same cycle as a software clear of the same event bit. The only set that can share a cycle with a write to the event register is a rising edge of `rx_valid`. The bench therefore holds `rx_valid` low for a cycle, then raises it in exactly the cycle that writes 1 to bit 1 of address 3. A cycle-accurate behavioural model also checks every cycle of a long random run, in which stream readiness and bus accesses collide freely.

// File: rtl/mmio_sidefx_regs.sv
`timescale 1ns/1ps
module mmio_sidefx_regs #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] pio_o,
  output logic          irq
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_RCST = AW'(2);
  localparam logic [AW-1:0] A_EVT  = AW'(3);
  localparam logic [AW-1:0] A_PIO  = AW'(4);

  logic [DW-1:0] ctrl_q, pio_q;
  logic [1:0]    rc_q, evt_q;
  logic          rxv_q;

  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire rd_data = bus_rd && bus_addr == A_DATA;
  wire rd_rc   = bus_rd && bus_addr == A_RCST;
  wire wr_evt  = bus_wr && bus_addr == A_EVT;

  assign tx_valid = wr_data && tx_ready;
  assign tx_data  = bus_wdata;
  assign rx_ready = rd_data && rx_valid;

  wire [1:0] rc_set  = {wr_data && !tx_ready, rd_data && !rx_valid};
  wire [1:0] evt_set = {rx_valid && !rxv_q, tx_valid};
  wire [1:0] evt_clr = wr_evt ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pio_q  <= '0;
      rc_q   <= '0;
      evt_q  <= '0;
      rxv_q  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata;
      if (bus_wr && bus_addr == A_PIO)  pio_q  <= bus_wdata;
      rc_q  <= (rd_rc ? 2'b00 : rc_q) | rc_set;
      evt_q <= (evt_q & ~evt_clr) | evt_set;
      rxv_q <= rx_valid;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata = rx_valid ? rx_data : '0;
        A_CTRL:  bus_rdata = ctrl_q;
        A_RCST:  bus_rdata = DW'(rc_q);
        A_EVT:   bus_rdata = DW'(evt_q);
        A_PIO:   bus_rdata = pio_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign pio_o  = pio_q;
  assign irq    = |{rc_q, evt_q};
endmodule

// File: rtl/mmio_sidefx_chk.sv
`timescale 1ns/1ps
module mmio_sidefx_chk #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_rdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] ctrl_o,
  input logic [DW-1:0] pio_o,
  input logic [1:0]    rc_q,
  input logic [1:0]    evt_q,
  input logic          rxv_q
);
  p_no_blind_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_ready);
  p_no_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_valid && bus_rd && bus_addr == AW'(0)));
  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(1)) |=> $stable(ctrl_o));
  p_pio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(4)) |=> $stable(pio_o));
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(2)) |=> rc_q == 2'b00);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rxv_q) |=> evt_q[1]);
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > AW'(4)) |-> bus_rdata == '0);
endmodule

bind mmio_sidefx_regs mmio_sidefx_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .ctrl_o(ctrl_o), .pio_o(pio_o), .rc_q(rc_q), .evt_q(evt_q), .rxv_q(rxv_q)
);

// File: tb/mmio_sidefx_regs_tb.sv
`timescale 1ns/1ps
module mmio_sidefx_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic [7:0] ctrl_o, pio_o;
  logic       irq;

  always #4 clk = ~clk;

  mmio_sidefx_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ctrl_o(ctrl_o), .pio_o(pio_o), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [7:0] m_ctrl = '0, m_pio = '0;
  logic [1:0] m_rc = '0, m_evt = '0;
  bit         m_rxprev = 1'b0;
  int         tx_count = 0;
  logic [7:0] last_rd;
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] a, input bit w, input logic [7:0] wd, input bit r,
                     input bit txr, input bit rxv, input logic [7:0] rxd);
    logic [7:0] e_rd;
    bit e_tx, e_pop, e_ovf, e_udf;
    string rtag;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = wd; bus_rd = r;
    tx_ready = txr; rx_valid = rxv; rx_data = rxd;
    #2;
    e_tx  = w && a == 3'd0 && txr;
    e_pop = r && a == 3'd0 && rxv;
    e_ovf = w && a == 3'd0 && !txr;
    e_udf = r && a == 3'd0 && !rxv;
    e_rd = 8'h00; rtag = "R10 rdata";
    if (r) begin
      case (a)
        3'd0: begin e_rd = rxv ? rxd : 8'h00; rtag = "R3 data read"; end
        3'd1: begin e_rd = m_ctrl; rtag = "R5 ctrl read"; end
        3'd2: begin e_rd = {6'b0, m_rc}; rtag = "R7 rc read"; end
        3'd3: begin e_rd = {6'b0, m_evt}; rtag = "R8 evt read"; end
        3'd4: begin e_rd = m_pio; rtag = "R6 pio read"; end
        default: ;
      endcase
    end
    last_rd = bus_rdata;
    chk(bus_rdata === e_rd, rtag, bus_rdata, e_rd);
    chk(tx_valid === e_tx, "R1 tx_valid", tx_valid, e_tx);
    if (e_tx) chk(tx_data === wd, "R1 tx_data", tx_data, wd);
    chk(rx_ready === e_pop, "R4 rx_ready", rx_ready, e_pop);
    chk(ctrl_o === m_ctrl, "R5 ctrl_o", ctrl_o, m_ctrl);
    chk(pio_o === m_pio, "R6 pio_o", pio_o, m_pio);
    chk(irq === (|{m_rc, m_evt}), "R11 irq", irq, |{m_rc, m_evt});
    if (e_tx) tx_count++;
    @(posedge clk);
    if (w && a == 3'd1) m_ctrl = wd;
    if (w && a == 3'd4) m_pio = wd;
    if (r && a == 3'd2) m_rc = 2'b00;
    if (e_ovf) m_rc[1] = 1'b1;
    if (e_udf) m_rc[0] = 1'b1;
    if (w && a == 3'd3) m_evt = m_evt & ~wd[1:0];
    if (e_tx) m_evt[0] = 1'b1;
    if (rxv && !m_rxprev) m_evt[1] = 1'b1;
    m_rxprev = rxv;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [7:0] exp, input string tag);
    cyc(a, 0, 8'h00, 1, 1, 0, 8'h00);
    chk(last_rd === exp, tag, last_rd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R11 reset state
    chk(ctrl_o === 8'h00 && pio_o === 8'h00 && irq === 1'b0, "R11 reset", {ctrl_o, pio_o}, 0);
    cyc(3'd0, 0, 8'h00, 0, 1, 0, 8'h00);
    // R5 control register, rewrite same value
    cyc(3'd1, 1, 8'h5A, 0, 1, 0, 8'h00);
    rd_expect(3'd1, 8'h5A, "R5 ctrl stored");
    cyc(3'd1, 1, 8'h5A, 0, 1, 0, 8'h00);
    chk(ctrl_o === 8'h5A && irq === 1'b0, "R5 rewrite no effect", {ctrl_o, 7'b0, irq}, 16'h5A00);
    // R6 parallel output
    cyc(3'd4, 1, 8'hC3, 0, 1, 0, 8'h00);
    cyc(3'd4, 1, 8'hC3, 0, 1, 0, 8'h00);
    chk(pio_o === 8'hC3, "R6 pins", pio_o, 8'hC3);
    rd_expect(3'd4, 8'hC3, "R6 pio read");
    // R1 same value twice -> two transfers
    tx_count = 0;
    cyc(3'd0, 1, 8'h41, 0, 1, 0, 8'h00);
    cyc(3'd0, 1, 8'h41, 0, 1, 0, 8'h00);
    chk(tx_count == 2, "R1 two sends", tx_count, 2);
    rd_expect(3'd3, 8'h01, "R9 tx event set");
    // R8 write 0 no effect, write 1 clears
    cyc(3'd3, 1, 8'h00, 0, 1, 0, 8'h00);
    rd_expect(3'd3, 8'h01, "R8 write zero ignored");
    cyc(3'd3, 1, 8'h01, 0, 1, 0, 8'h00);
    rd_expect(3'd3, 8'h00, "R8 write one clears");
    // R2 dropped write
    tx_count = 0;
    cyc(3'd0, 1, 8'h77, 0, 0, 0, 8'h00);
    chk(tx_count == 0, "R2 dropped", tx_count, 0);
    rd_expect(3'd2, 8'h02, "R2 overrun flag");
    rd_expect(3'd2, 8'h00, "R7 cleared by read");
    // R3 pop, R4 empty read
    cyc(3'd0, 0, 8'h00, 0, 1, 1, 8'h99);
    cyc(3'd0, 0, 8'h00, 1, 1, 1, 8'h99);
    chk(last_rd === 8'h99, "R3 popped byte", last_rd, 8'h99);
    cyc(3'd0, 0, 8'h00, 1, 1, 0, 8'h00);
    chk(last_rd === 8'h00, "R4 empty reads zero", last_rd, 8'h00);
    rd_expect(3'd2, 8'h01, "R4 underrun flag");
    rd_expect(3'd3, 8'h02, "R9 rx arrival set");
    cyc(3'd3, 1, 8'h02, 0, 1, 0, 8'h00);
    rd_expect(3'd3, 8'h00, "R8 rx event cleared");
    // R9 set wins over clear in same cycle
    cyc(3'd3, 1, 8'h02, 0, 1, 1, 8'h10);
    cyc(3'd0, 0, 8'h00, 0, 1, 1, 8'h10);
    chk(irq === 1'b1, "R9 set wins irq", irq, 1);
    cyc(3'd3, 0, 8'h00, 1, 1, 0, 8'h00);
    chk(last_rd === 8'h02, "R9 set wins", last_rd, 8'h02);
    // R10 unmapped
    for (int a = 5; a < 8; a++) begin
      cyc(3'(a), 1, 8'hFF, 0, 1, 0, 8'h00);
      rd_expect(3'(a), 8'h00, "R10 unmapped reads zero");
    end
    chk(ctrl_o === 8'h5A && pio_o === 8'hC3, "R10 writes ignored", {ctrl_o, pio_o}, 16'h5AC3);
    // mixed random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      cyc(3'(rv[2:0]), rv[3], 8'(rv[15:8]), rv[4], rv[5], rv[6] & rv[7], 8'(rv[23:16]));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule